// File: doc/BRIEF.md
# Range-Mapped AXI Address Translator

This block sits between an internal AXI master and an external network. It can either pass every request through unchanged (bypass) or filter and rewrite request addresses using a table of software-programmed range entries. Each entry names an inclusive span of input pages, an output base page, and two flags: active and write-protected. A 48-bit address splits into a 36-bit page number and a 12-bit page offset. A matching request leaves the block with its page moved to the same distance above the output base, and its offset is kept.

A request that finds no active entry is stopped inside the block. So is a write that lands in a write-protected span. The block answers it locally with an AXI error, and the network never sees it. Reads and writes have separate lookups and separate control state machines, so one direction never stalls the other. The table and the enable bit are reset only by the system reset. The datapath state machines have their own reset, so the datapath can be restarted without reprogramming the table.

Write control states: `WR_IDLE` (wait for AW), `WR_PASS` (forward W beats up to WLAST), `WR_SINK` (absorb W beats of a denied write), `WR_RESP` (present the local error B). Transitions: IDLE→PASS when a permitted AW is accepted downstream; IDLE→SINK when a denied AW is taken; PASS→IDLE on the last forwarded W beat; SINK→RESP on the last absorbed W beat; RESP→IDLE when B is accepted. Read control states: `RD_IDLE` (forward permitted AR, pass R through) and `RD_ERR` (emit error beats). Transitions: IDLE→ERR when a denied AR is taken; ERR→IDLE when the final error beat is accepted.

Top module: `axi_range_xlate`

## Requirements
- R1: After system reset the enable bit reads 0. AW and AR requests are then forwarded with address, ID and length unchanged, whatever the table holds.
- R2: Configuration address map. If `cfg_addr[5]` = 1, the global enable is selected, held in data bit 0. If `cfg_addr[5]` = 0, `cfg_addr[4:2]` selects the entry and `cfg_addr[1:0]` selects the field: 0 = first page, 1 = last page, 2 = output base page, 3 = flags (bit 0 active, bit 1 write-protected). A write takes effect at the clock edge where `cfg_we` is high. The read data is combinational from `cfg_addr`.
- R3: With enable set, an active entry matches when first ≤ page ≤ last. The forwarded page is then base + (page − first), and address bits [11:0] are kept. Inactive entries never match.
- R4: When several entries match, the entry with the lowest index decides both the translation and the protection.
- R5: A read with no match is not forwarded. The block returns ARLEN+1 R beats with RRESP = 2'b10, zero data and the request's ID, and sets RLAST only on the final beat. These beats start in the cycle after the AR handshake.
- R6: A write with no match, or a write that matches a write-protected entry, is not forwarded. All of its W beats are accepted and dropped. After the last W beat, exactly one B with BRESP = 2'b10 and the request's ID is returned.
- R7: A read that matches a write-protected entry is forwarded and translated.
- R8: Asserting the datapath reset alone leaves the table and the enable bit unchanged.
- R9: The read side keeps forwarding while the write side is sinking a denied write. Responses from the network pass through unchanged whenever no local error response is being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low; clears table, enable and datapath |
| dp_rst_n | input | 1 | Datapath reset, active low; clears only the state machines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration register select |
| cfg_wdata | input | 36 | Configuration write data |
| cfg_rdata | output | 36 | Configuration read data |
| s_aw_valid | input | 1 | Upstream AW valid |
| s_aw_ready | output | 1 | Upstream AW ready |
| s_aw_id | input | 4 | Upstream AW ID |
| s_aw_addr | input | 48 | Upstream AW address |
| s_aw_len | input | 8 | Upstream AW burst length |
| m_aw_valid | output | 1 | Downstream AW valid |
| m_aw_ready | input | 1 | Downstream AW ready |
| m_aw_id | output | 4 | Downstream AW ID |
| m_aw_addr | output | 48 | Downstream AW address |
| m_aw_len | output | 8 | Downstream AW burst length |
| s_w_valid | input | 1 | Upstream W valid |
| s_w_ready | output | 1 | Upstream W ready |
| s_w_data | input | 64 | Upstream W data |
| s_w_last | input | 1 | Upstream W last |
| m_w_valid | output | 1 | Downstream W valid |
| m_w_ready | input | 1 | Downstream W ready |
| m_w_data | output | 64 | Downstream W data |
| m_w_last | output | 1 | Downstream W last |
| s_b_valid | output | 1 | Upstream B valid |
| s_b_ready | input | 1 | Upstream B ready |
| s_b_id | output | 4 | Upstream B ID |
| s_b_resp | output | 2 | Upstream B response |
| m_b_valid | input | 1 | Downstream B valid |
| m_b_ready | output | 1 | Downstream B ready |
| m_b_id | input | 4 | Downstream B ID |
| m_b_resp | input | 2 | Downstream B response |
| s_ar_valid | input | 1 | Upstream AR valid |
| s_ar_ready | output | 1 | Upstream AR ready |
| s_ar_id | input | 4 | Upstream AR ID |
| s_ar_addr | input | 48 | Upstream AR address |
| s_ar_len | input | 8 | Upstream AR burst length |
| m_ar_valid | output | 1 | Downstream AR valid |
| m_ar_ready | input | 1 | Downstream AR ready |
| m_ar_id | output | 4 | Downstream AR ID |
| m_ar_addr | output | 48 | Downstream AR address |
| m_ar_len | output | 8 | Downstream AR burst length |
| s_r_valid | output | 1 | Upstream R valid |
| s_r_ready | input | 1 | Upstream R ready |
| s_r_id | output | 4 | Upstream R ID |
| s_r_data | output | 64 | Upstream R data |
| s_r_resp | output | 2 | Upstream R response |
| s_r_last | output | 1 | Upstream R last |
| m_r_valid | input | 1 | Downstream R valid |
| m_r_ready | output | 1 | Downstream R ready |
| m_r_id | input | 4 | Downstream R ID |
| m_r_data | input | 64 | Downstream R data |
| m_r_resp | input | 2 | Downstream R response |
| m_r_last | input | 1 | Downstream R last |

## Verification
Forwarding decisions and rewritten addresses are combinational from the request inputs. The bench drives a request just after a falling edge and samples the downstream channel 1 ns later, in the same cycle. Table writes become visible after the next rising edge, so read-back happens one falling edge later. A denied read shows its first error beat in the cycle after the AR handshake, and one more beat follows for each accepted beat. A denied write shows its B one cycle after the last absorbed W beat. The bench walks these beats one falling edge at a time and compares each against a table model that it keeps itself.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_PASS,
        WR_SINK,
        WR_RESP
    } wr_state_e;

    typedef enum logic {
        RD_IDLE,
        RD_ERR
    } rd_state_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

    localparam int FLD_FIRST = 0;
    localparam int FLD_LAST  = 1;
    localparam int FLD_BASE  = 2;
    localparam int FLD_FLAGS = 3;

endpackage

// File: rtl/xlate_cfg.sv
module xlate_cfg #(
    parameter int N_ENT  = 8,
    parameter int PAGE_W = 36,
    parameter int CFG_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [PAGE_W-1:0] wdata,
    output logic [PAGE_W-1:0] rdata,
    output logic              en,
    output logic [PAGE_W-1:0] first_pg [N_ENT],
    output logic [PAGE_W-1:0] last_pg  [N_ENT],
    output logic [PAGE_W-1:0] base_pg  [N_ENT],
    output logic              act      [N_ENT],
    output logic              wprot    [N_ENT]
);
    import xlate_pkg::*;

    localparam int IDX_W = $clog2(N_ENT);

    logic             glb_sel;
    logic [IDX_W-1:0] idx;
    logic [1:0]       fld;

    assign glb_sel = addr[CFG_AW-1];
    assign idx     = addr[IDX_W+1:2];
    assign fld     = addr[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en <= 1'b0;
            for (int i = 0; i < N_ENT; i++) begin
                first_pg[i] <= '0;
                last_pg[i]  <= '0;
                base_pg[i]  <= '0;
                act[i]      <= 1'b0;
                wprot[i]    <= 1'b0;
            end
        end else if (we) begin
            if (glb_sel) begin
                en <= wdata[0];
            end else begin
                unique case (int'(fld))
                    FLD_FIRST: first_pg[idx] <= wdata;
                    FLD_LAST:  last_pg[idx]  <= wdata;
                    FLD_BASE:  base_pg[idx]  <= wdata;
                    default: begin
                        act[idx]   <= wdata[0];
                        wprot[idx] <= wdata[1];
                    end
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (glb_sel) begin
            rdata[0] = en;
        end else begin
            unique case (int'(fld))
                FLD_FIRST: rdata = first_pg[idx];
                FLD_LAST:  rdata = last_pg[idx];
                FLD_BASE:  rdata = base_pg[idx];
                default: begin
                    rdata[0] = act[idx];
                    rdata[1] = wprot[idx];
                end
            endcase
        end
    end

endmodule

// File: rtl/xlate_lookup.sv
module xlate_lookup #(
    parameter int N_ENT  = 8,
    parameter int PAGE_W = 36
) (
    input  logic [PAGE_W-1:0] page,
    input  logic              is_write,
    input  logic [PAGE_W-1:0] first_pg [N_ENT],
    input  logic [PAGE_W-1:0] last_pg  [N_ENT],
    input  logic [PAGE_W-1:0] base_pg  [N_ENT],
    input  logic              act      [N_ENT],
    input  logic              wprot    [N_ENT],
    output logic              allow,
    output logic [PAGE_W-1:0] out_page
);
    logic [N_ENT-1:0] hit_vec;

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign hit_vec[g] = act[g] && (page >= first_pg[g]) && (page <= last_pg[g]);
    end

    // scan from the top down so the lowest index is applied last and wins
    always_comb begin
        allow    = 1'b0;
        out_page = page;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                allow    = !(is_write && wprot[i]);
                out_page = base_pg[i] + (page - first_pg[i]);
            end
        end
    end

endmodule

// File: rtl/xlate_wr_fsm.sv
module xlate_wr_fsm #(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            aw_valid,
    input  logic            aw_pass,
    input  logic [ID_W-1:0] aw_id,
    output logic            aw_ready,
    output logic            fwd_aw_valid,
    input  logic            fwd_aw_ready,
    input  logic            w_valid,
    input  logic            w_last,
    output logic            w_ready,
    output logic            fwd_w_valid,
    input  logic            fwd_w_ready,
    output logic            b_valid,
    output logic [ID_W-1:0] b_id,
    output logic [1:0]      b_resp,
    input  logic            b_ready,
    input  logic            net_b_valid,
    input  logic [ID_W-1:0] net_b_id,
    input  logic [1:0]      net_b_resp,
    output logic            net_b_ready,
    output logic            sinking,
    output logic            err_resp
);
    import xlate_pkg::*;

    wr_state_e       state, state_nx;
    logic [ID_W-1:0] err_id;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= WR_IDLE;
            err_id <= '0;
        end else begin
            state <= state_nx;
            if (state == WR_IDLE && aw_valid && !aw_pass) begin
                err_id <= aw_id;
            end
        end
    end

    always_comb begin
        state_nx     = state;
        aw_ready     = 1'b0;
        fwd_aw_valid = 1'b0;
        w_ready      = 1'b0;
        fwd_w_valid  = 1'b0;
        b_valid      = net_b_valid;
        b_id         = net_b_id;
        b_resp       = net_b_resp;
        net_b_ready  = b_ready;
        unique case (state)
            WR_IDLE: begin
                if (aw_valid) begin
                    if (aw_pass) begin
                        fwd_aw_valid = 1'b1;
                        aw_ready     = fwd_aw_ready;
                        if (fwd_aw_ready) state_nx = WR_PASS;
                    end else begin
                        aw_ready = 1'b1;
                        state_nx = WR_SINK;
                    end
                end
            end
            WR_PASS: begin
                fwd_w_valid = w_valid;
                w_ready     = fwd_w_ready;
                if (w_valid && fwd_w_ready && w_last) state_nx = WR_IDLE;
            end
            WR_SINK: begin
                w_ready = 1'b1;
                if (w_valid && w_last) state_nx = WR_RESP;
            end
            WR_RESP: begin
                b_valid     = 1'b1;
                b_id        = err_id;
                b_resp      = RESP_SLVERR;
                net_b_ready = 1'b0;
                if (b_ready) state_nx = WR_IDLE;
            end
        endcase
    end

    assign sinking  = (state == WR_SINK);
    assign err_resp = (state == WR_RESP);

endmodule

// File: rtl/xlate_rd_fsm.sv
module xlate_rd_fsm #(
    parameter int ID_W   = 4,
    parameter int LEN_W  = 8,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ar_valid,
    input  logic              ar_pass,
    input  logic [ID_W-1:0]   ar_id,
    input  logic [LEN_W-1:0]  ar_len,
    output logic              ar_ready,
    output logic              fwd_ar_valid,
    input  logic              fwd_ar_ready,
    output logic              r_valid,
    input  logic              r_ready,
    output logic [ID_W-1:0]   r_id,
    output logic [DATA_W-1:0] r_data,
    output logic [1:0]        r_resp,
    output logic              r_last,
    input  logic              net_r_valid,
    output logic              net_r_ready,
    input  logic [ID_W-1:0]   net_r_id,
    input  logic [DATA_W-1:0] net_r_data,
    input  logic [1:0]        net_r_resp,
    input  logic              net_r_last,
    output logic              err_busy
);
    import xlate_pkg::*;

    rd_state_e        state, state_nx;
    logic [ID_W-1:0]  err_id;
    logic [LEN_W-1:0] beats_left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= RD_IDLE;
            err_id     <= '0;
            beats_left <= '0;
        end else begin
            state <= state_nx;
            if (state == RD_IDLE && ar_valid && !ar_pass) begin
                err_id     <= ar_id;
                beats_left <= ar_len;
            end else if (state == RD_ERR && r_ready) begin
                beats_left <= beats_left - 1'b1;
            end
        end
    end

    always_comb begin
        state_nx     = state;
        ar_ready     = 1'b0;
        fwd_ar_valid = 1'b0;
        r_valid      = net_r_valid;
        r_id         = net_r_id;
        r_data       = net_r_data;
        r_resp       = net_r_resp;
        r_last       = net_r_last;
        net_r_ready  = r_ready;
        unique case (state)
            RD_IDLE: begin
                if (ar_valid) begin
                    if (ar_pass) begin
                        fwd_ar_valid = 1'b1;
                        ar_ready     = fwd_ar_ready;
                    end else begin
                        ar_ready = 1'b1;
                        state_nx = RD_ERR;
                    end
                end
            end
            RD_ERR: begin
                r_valid     = 1'b1;
                r_id        = err_id;
                r_data      = '0;
                r_resp      = RESP_SLVERR;
                r_last      = (beats_left == '0);
                net_r_ready = 1'b0;
                if (r_ready && beats_left == '0) state_nx = RD_IDLE;
            end
        endcase
    end

    assign err_busy = (state == RD_ERR);

endmodule

// File: rtl/axi_range_xlate.sv
module axi_range_xlate #(
    parameter int N_ENT  = 8,
    parameter int ADDR_W = 48,
    parameter int OFS_W  = 12,
    parameter int ID_W   = 4,
    parameter int LEN_W  = 8,
    parameter int DATA_W = 64,
    localparam int PAGE_W = ADDR_W - OFS_W,
    localparam int CFG_AW = $clog2(N_ENT) + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dp_rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [PAGE_W-1:0] cfg_wdata,
    output logic [PAGE_W-1:0] cfg_rdata,
    input  logic              s_aw_valid,
    output logic              s_aw_ready,
    input  logic [ID_W-1:0]   s_aw_id,
    input  logic [ADDR_W-1:0] s_aw_addr,
    input  logic [LEN_W-1:0]  s_aw_len,
    output logic              m_aw_valid,
    input  logic              m_aw_ready,
    output logic [ID_W-1:0]   m_aw_id,
    output logic [ADDR_W-1:0] m_aw_addr,
    output logic [LEN_W-1:0]  m_aw_len,
    input  logic              s_w_valid,
    output logic              s_w_ready,
    input  logic [DATA_W-1:0] s_w_data,
    input  logic              s_w_last,
    output logic              m_w_valid,
    input  logic              m_w_ready,
    output logic [DATA_W-1:0] m_w_data,
    output logic              m_w_last,
    output logic              s_b_valid,
    input  logic              s_b_ready,
    output logic [ID_W-1:0]   s_b_id,
    output logic [1:0]        s_b_resp,
    input  logic              m_b_valid,
    output logic              m_b_ready,
    input  logic [ID_W-1:0]   m_b_id,
    input  logic [1:0]        m_b_resp,
    input  logic              s_ar_valid,
    output logic              s_ar_ready,
    input  logic [ID_W-1:0]   s_ar_id,
    input  logic [ADDR_W-1:0] s_ar_addr,
    input  logic [LEN_W-1:0]  s_ar_len,
    output logic              m_ar_valid,
    input  logic              m_ar_ready,
    output logic [ID_W-1:0]   m_ar_id,
    output logic [ADDR_W-1:0] m_ar_addr,
    output logic [LEN_W-1:0]  m_ar_len,
    output logic              s_r_valid,
    input  logic              s_r_ready,
    output logic [ID_W-1:0]   s_r_id,
    output logic [DATA_W-1:0] s_r_data,
    output logic [1:0]        s_r_resp,
    output logic              s_r_last,
    input  logic              m_r_valid,
    output logic              m_r_ready,
    input  logic [ID_W-1:0]   m_r_id,
    input  logic [DATA_W-1:0] m_r_data,
    input  logic [1:0]        m_r_resp,
    input  logic              m_r_last
);
    logic              en;
    logic [PAGE_W-1:0] first_pg [N_ENT];
    logic [PAGE_W-1:0] last_pg  [N_ENT];
    logic [PAGE_W-1:0] base_pg  [N_ENT];
    logic              act      [N_ENT];
    logic              wprot    [N_ENT];

    logic              aw_allow, ar_allow, aw_pass, ar_pass;
    logic [PAGE_W-1:0] aw_page_out, ar_page_out;
    logic              dp_rst_all_n;
    logic              wr_sinking, wr_err_resp, rd_err_busy;

    assign dp_rst_all_n = rst_n && dp_rst_n;

    xlate_cfg #(.N_ENT(N_ENT), .PAGE_W(PAGE_W), .CFG_AW(CFG_AW)) u_cfg (
        .clk, .rst_n,
        .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
        .en, .first_pg, .last_pg, .base_pg, .act, .wprot
    );

    xlate_lookup #(.N_ENT(N_ENT), .PAGE_W(PAGE_W)) u_aw_lkp (
        .page(s_aw_addr[ADDR_W-1:OFS_W]), .is_write(1'b1),
        .first_pg, .last_pg, .base_pg, .act, .wprot,
        .allow(aw_allow), .out_page(aw_page_out)
    );

    xlate_lookup #(.N_ENT(N_ENT), .PAGE_W(PAGE_W)) u_ar_lkp (
        .page(s_ar_addr[ADDR_W-1:OFS_W]), .is_write(1'b0),
        .first_pg, .last_pg, .base_pg, .act, .wprot,
        .allow(ar_allow), .out_page(ar_page_out)
    );

    assign aw_pass   = !en || aw_allow;
    assign ar_pass   = !en || ar_allow;
    assign m_aw_addr = en ? {aw_page_out, s_aw_addr[OFS_W-1:0]} : s_aw_addr;
    assign m_ar_addr = en ? {ar_page_out, s_ar_addr[OFS_W-1:0]} : s_ar_addr;
    assign m_aw_id   = s_aw_id;
    assign m_aw_len  = s_aw_len;
    assign m_ar_id   = s_ar_id;
    assign m_ar_len  = s_ar_len;
    assign m_w_data  = s_w_data;
    assign m_w_last  = s_w_last;

    xlate_wr_fsm #(.ID_W(ID_W)) u_wr (
        .clk, .rst_n(dp_rst_all_n),
        .aw_valid(s_aw_valid), .aw_pass, .aw_id(s_aw_id), .aw_ready(s_aw_ready),
        .fwd_aw_valid(m_aw_valid), .fwd_aw_ready(m_aw_ready),
        .w_valid(s_w_valid), .w_last(s_w_last), .w_ready(s_w_ready),
        .fwd_w_valid(m_w_valid), .fwd_w_ready(m_w_ready),
        .b_valid(s_b_valid), .b_id(s_b_id), .b_resp(s_b_resp), .b_ready(s_b_ready),
        .net_b_valid(m_b_valid), .net_b_id(m_b_id), .net_b_resp(m_b_resp),
        .net_b_ready(m_b_ready),
        .sinking(wr_sinking), .err_resp(wr_err_resp)
    );

    xlate_rd_fsm #(.ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_rd (
        .clk, .rst_n(dp_rst_all_n),
        .ar_valid(s_ar_valid), .ar_pass, .ar_id(s_ar_id), .ar_len(s_ar_len),
        .ar_ready(s_ar_ready),
        .fwd_ar_valid(m_ar_valid), .fwd_ar_ready(m_ar_ready),
        .r_valid(s_r_valid), .r_ready(s_r_ready), .r_id(s_r_id), .r_data(s_r_data),
        .r_resp(s_r_resp), .r_last(s_r_last),
        .net_r_valid(m_r_valid), .net_r_ready(m_r_ready), .net_r_id(m_r_id),
        .net_r_data(m_r_data), .net_r_resp(m_r_resp), .net_r_last(m_r_last),
        .err_busy(rd_err_busy)
    );

endmodule

// File: rtl/xlate_checker.sv
module xlate_checker #(
    parameter int ADDR_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dp_rst_n,
    input logic              cfg_we,
    input logic              en,
    input logic              ar_allow,
    input logic              rd_err_busy,
    input logic              wr_sinking,
    input logic              wr_err_resp,
    input logic              s_ar_valid,
    input logic [ADDR_W-1:0] s_ar_addr,
    input logic              m_ar_valid,
    input logic [ADDR_W-1:0] m_ar_addr,
    input logic              s_r_valid,
    input logic              s_r_ready,
    input logic              s_r_last,
    input logic [1:0]        s_r_resp,
    input logic              m_r_ready,
    input logic              m_w_valid,
    input logic              s_w_ready,
    input logic              s_b_valid,
    input logic [1:0]        s_b_resp,
    input logic              m_b_ready
);

    assert_bypass_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n || !dp_rst_n)
        (!en && s_ar_valid && !rd_err_busy) |-> (m_ar_valid && m_ar_addr == s_ar_addr));

    assert_enable_hold_R2: assert property (@(posedge clk) disable iff (!rst_n || !dp_rst_n)
        !cfg_we |=> $stable(en));

    assert_denied_read_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n || !dp_rst_n)
        (en && s_ar_valid && !ar_allow) |-> !m_ar_valid);

    assert_err_beat_R5: assert property (@(posedge clk) disable iff (!rst_n || !dp_rst_n)
        rd_err_busy |-> (s_r_valid && s_r_resp == 2'b10 && !m_r_ready && !m_ar_valid));

    assert_err_last_ends_R5: assert property (@(posedge clk) disable iff (!rst_n || !dp_rst_n)
        (rd_err_busy && s_r_valid && s_r_ready && s_r_last) |=> !rd_err_busy);

    assert_err_midburst_R5: assert property (@(posedge clk) disable iff (!rst_n || !dp_rst_n)
        (rd_err_busy && s_r_ready && !s_r_last) |=> rd_err_busy);

    assert_sink_no_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n || !dp_rst_n)
        wr_sinking |-> (!m_w_valid && s_w_ready));

    assert_err_b_R6: assert property (@(posedge clk) disable iff (!rst_n || !dp_rst_n)
        wr_err_resp |-> (s_b_valid && s_b_resp == 2'b10 && !m_b_ready));

endmodule

bind axi_range_xlate xlate_checker #(.ADDR_W(ADDR_W)) u_xlate_chk (
    .clk(clk), .rst_n(rst_n), .dp_rst_n(dp_rst_n), .cfg_we(cfg_we), .en(en),
    .ar_allow(ar_allow), .rd_err_busy(rd_err_busy), .wr_sinking(wr_sinking),
    .wr_err_resp(wr_err_resp), .s_ar_valid(s_ar_valid), .s_ar_addr(s_ar_addr),
    .m_ar_valid(m_ar_valid), .m_ar_addr(m_ar_addr), .s_r_valid(s_r_valid),
    .s_r_ready(s_r_ready), .s_r_last(s_r_last), .s_r_resp(s_r_resp),
    .m_r_ready(m_r_ready), .m_w_valid(m_w_valid), .s_w_ready(s_w_ready),
    .s_b_valid(s_b_valid), .s_b_resp(s_b_resp), .m_b_ready(m_b_ready)
);

// File: tb/axi_range_xlate_bench.sv
`timescale 1ns/1ps
module axi_range_xlate_bench;
    localparam int AW = 48, PW = 36, IW = 4, LW = 8, DW = 64;

    logic clk = 0, rst_n = 0, dp_rst_n = 0;
    logic cfg_we = 0; logic [5:0] cfg_addr = '0; logic [PW-1:0] cfg_wdata = '0, cfg_rdata;
    logic s_aw_valid = 0, s_aw_ready; logic [IW-1:0] s_aw_id = '0; logic [AW-1:0] s_aw_addr = '0; logic [LW-1:0] s_aw_len = '0;
    logic m_aw_valid, m_aw_ready = 1; logic [IW-1:0] m_aw_id; logic [AW-1:0] m_aw_addr; logic [LW-1:0] m_aw_len;
    logic s_w_valid = 0, s_w_ready, s_w_last = 0; logic [DW-1:0] s_w_data = '0;
    logic m_w_valid, m_w_ready = 1, m_w_last; logic [DW-1:0] m_w_data;
    logic s_b_valid, s_b_ready = 1; logic [IW-1:0] s_b_id; logic [1:0] s_b_resp;
    logic m_b_valid = 0, m_b_ready; logic [IW-1:0] m_b_id = '0; logic [1:0] m_b_resp = '0;
    logic s_ar_valid = 0, s_ar_ready; logic [IW-1:0] s_ar_id = '0; logic [AW-1:0] s_ar_addr = '0; logic [LW-1:0] s_ar_len = '0;
    logic m_ar_valid, m_ar_ready = 1; logic [IW-1:0] m_ar_id; logic [AW-1:0] m_ar_addr; logic [LW-1:0] m_ar_len;
    logic s_r_valid, s_r_ready = 1, s_r_last; logic [IW-1:0] s_r_id; logic [DW-1:0] s_r_data; logic [1:0] s_r_resp;
    logic m_r_valid = 0, m_r_ready, m_r_last = 0; logic [IW-1:0] m_r_id = '0; logic [DW-1:0] m_r_data = '0; logic [1:0] m_r_resp = '0;

    int checks = 0, errors = 0;
    logic [PW-1:0] mf [8], ml [8], mb [8];
    bit mv [8], mr [8], men;

    always #2.5 clk = ~clk;

    axi_range_xlate u_axi_range_xlate (.*);

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] fa(input int idx, input int fld);
        return {1'b0, idx[2:0], fld[1:0]};
    endfunction

    function automatic void model(input logic [PW-1:0] pg, input bit wr, output bit ok, output logic [PW-1:0] op);
        ok = 1; op = pg;
        if (!men) return;
        ok = 0;
        for (int i = 0; i < 8; i++) begin
            if (mv[i] && pg >= mf[i] && pg <= ml[i]) begin
                ok = !(wr && mr[i]);
                op = mb[i] + (pg - mf[i]);
                break;
            end
        end
    endfunction

    task automatic cfg_wr(input logic [5:0] a, input logic [PW-1:0] d);
        @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic cfg_rd_chk(input string req, input logic [5:0] a, input logic [PW-1:0] exp);
        @(negedge clk); cfg_addr = a; #1;
        chk(req, "cfg readback", cfg_rdata, exp);
    endtask

    task automatic prog(input int i, input logic [PW-1:0] f, input logic [PW-1:0] l,
                        input logic [PW-1:0] b, input bit v, input bit r);
        cfg_wr(fa(i, 0), f); cfg_wr(fa(i, 1), l); cfg_wr(fa(i, 2), b);
        cfg_wr(fa(i, 3), {34'd0, r, v});
        mf[i] = f; ml[i] = l; mb[i] = b; mv[i] = v; mr[i] = r;
    endtask

    task automatic set_en(input bit e);
        cfg_wr(6'h20, {35'd0, e}); men = e;
    endtask

    task automatic rd_probe(input string req, input logic [AW-1:0] a, input logic [LW-1:0] len, input logic [IW-1:0] id);
        bit ok; logic [PW-1:0] op;
        model(a[AW-1:12], 1'b0, ok, op);
        @(negedge clk); s_ar_valid = 1; s_ar_addr = a; s_ar_len = len; s_ar_id = id; #1;
        chk(req, "ar forwarded", m_ar_valid, ok);
        if (ok) begin
            chk(req, "ar addr", m_ar_addr, {op, a[11:0]});
            chk(req, "ar id/len", {m_ar_id, m_ar_len}, {id, len});
        end
        @(negedge clk); s_ar_valid = 0;
        if (!ok) begin
            for (int b = 0; b <= int'(len); b++) begin
                #1;
                chk("R5", "err beat valid/resp/id", {s_r_valid, s_r_resp, s_r_id}, {1'b1, 2'b10, id});
                chk("R5", "err beat last", s_r_last, (b == int'(len)));
                @(negedge clk);
            end
            #1; chk("R5", "no extra beat", s_r_valid, 0);
        end
    endtask

    task automatic wr_probe(input string req, input logic [AW-1:0] a, input int beats, input logic [IW-1:0] id);
        bit ok; logic [PW-1:0] op;
        model(a[AW-1:12], 1'b1, ok, op);
        @(negedge clk); s_aw_valid = 1; s_aw_addr = a; s_aw_id = id; s_aw_len = LW'(beats - 1); #1;
        chk(req, "aw forwarded", m_aw_valid, ok);
        if (ok) chk(req, "aw addr", m_aw_addr, {op, a[11:0]});
        @(negedge clk); s_aw_valid = 0;
        for (int b = 0; b < beats; b++) begin
            s_w_valid = 1; s_w_last = (b == beats - 1); s_w_data = 64'(b + 100); #1;
            chk(ok ? req : "R6", "w routed", {m_w_valid, s_w_ready}, {ok, 1'b1});
            @(negedge clk);
        end
        s_w_valid = 0; s_w_last = 0;
        if (!ok) begin
            #1; chk("R6", "err b", {s_b_valid, s_b_resp, s_b_id}, {1'b1, 2'b10, id});
            @(negedge clk); #1; chk("R6", "single b", s_b_valid, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) begin mf[i] = '0; ml[i] = '0; mb[i] = '0; mv[i] = 0; mr[i] = 0; end
        men = 0;
        repeat (3) @(negedge clk);
        rst_n = 1; dp_rst_n = 1;
        // R1: reset state and bypass
        cfg_rd_chk("R1", 6'h20, '0);
        @(negedge clk); #1; chk("R1", "idle outputs", {s_r_valid, s_b_valid, m_aw_valid}, 0);
        rd_probe("R1", 48'h1234_5678_9ABC, 8'd2, 4'h3);
        wr_probe("R1", 48'hFFFF_0000_0123, 2, 4'h5);

        // R2: programming and readback
        prog(0, 36'h100, 36'h1FF, 36'h8000, 1, 0);
        prog(1, 36'h180, 36'h2FF, 36'h9000, 1, 1);
        prog(2, 36'h400, 36'h400, 36'hA000, 1, 1);
        prog(3, 36'h500, 36'h5FF, 36'hB000, 0, 0);
        cfg_rd_chk("R2", fa(1, 0), 36'h180);
        cfg_rd_chk("R2", fa(1, 1), 36'h2FF);
        cfg_rd_chk("R2", fa(1, 2), 36'h9000);
        cfg_rd_chk("R2", fa(1, 3), 36'h3);
        rd_probe("R1", 48'h0000_0010_0000, 8'd0, 4'h1); // table loaded, still bypass
        set_en(1);
        cfg_rd_chk("R2", 6'h20, 36'h1);

        // directed translation cases
        rd_probe("R3", {36'h100, 12'h000}, 8'd0, 4'h2);
        rd_probe("R3", {36'h1FF, 12'hFFF}, 8'd0, 4'h2);
        rd_probe("R3", {36'h250, 12'h0AB}, 8'd1, 4'h4);
        rd_probe("R4", {36'h1A0, 12'h010}, 8'd0, 4'h6);
        wr_probe("R4", {36'h1A0, 12'h010}, 1, 4'h6);
        wr_probe("R6", {36'h250, 12'h000}, 3, 4'h7);
        rd_probe("R7", {36'h400, 12'h555}, 8'd0, 4'h8);
        wr_probe("R6", {36'h400, 12'h555}, 1, 4'h9);
        rd_probe("R3", {36'h550, 12'h000}, 8'd3, 4'hA);
        rd_probe("R5", {36'h0FF, 12'hFFF}, 8'd0, 4'hB);
        rd_probe("R5", {36'h300, 12'h000}, 8'd4, 4'hC);

        // R9: reads forwarded while a denied write is being sunk
        @(negedge clk); s_aw_valid = 1; s_aw_addr = {36'h700, 12'h0}; s_aw_id = 4'hD; s_aw_len = 0;
        @(negedge clk); s_aw_valid = 0;
        s_ar_valid = 1; s_ar_addr = {36'h120, 12'h004}; s_ar_id = 4'h1; #1;
        chk("R9", "ar forwarded during sink", {m_ar_valid, m_ar_addr}, {1'b1, 36'h8020, 12'h004});
        m_r_valid = 1; m_r_id = 4'h1; m_r_data = 64'hDEAD; m_r_last = 1; #1;
        chk("R9", "r passthrough", {s_r_valid, s_r_id, s_r_data}, {1'b1, 4'h1, 64'hDEAD});
        @(negedge clk); s_ar_valid = 0; m_r_valid = 0; m_r_last = 0;
        s_w_valid = 1; s_w_last = 1;
        @(negedge clk); s_w_valid = 0; s_w_last = 0;
        m_b_valid = 1; m_b_id = 4'h2; m_b_resp = 2'b00; #1;
        chk("R9", "err b has priority over network b", {s_b_id, s_b_resp, m_b_ready}, {4'hD, 2'b10, 1'b0});
        @(negedge clk); #1;
        chk("R9", "network b passthrough", {s_b_valid, s_b_id, s_b_resp, m_b_ready}, {1'b1, 4'h2, 2'b00, 1'b1});
        @(negedge clk); m_b_valid = 0;

        // R8: datapath reset keeps configuration
        dp_rst_n = 0; repeat (3) @(negedge clk); dp_rst_n = 1;
        cfg_rd_chk("R8", 6'h20, 36'h1);
        cfg_rd_chk("R8", fa(0, 2), 36'h8000);
        rd_probe("R8", {36'h110, 12'h321}, 8'd0, 4'h3);

        // constrained random mix
        for (int n = 0; n < 60; n++) begin
            logic [PW-1:0] pg; logic [11:0] of; logic [IW-1:0] id;
            pg = PW'($urandom_range(0, 32'h6FF)); of = 12'($urandom); id = IW'($urandom);
            if ($urandom_range(0, 1) == 0) rd_probe("R3", {pg, of}, LW'($urandom_range(0, 3)), id);
            else wr_probe("R6", {pg, of}, int'($urandom_range(1, 3)), id);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule